// File: doc/BRIEF.md
# Legacy Dish Switch Serializer

This block sends a seven-bit command to an older style of satellite dish switch by toggling one output line. The same line selects the LNB supply voltage when no command is being sent. A transmission has three parts. First a long high start pulse. Then a short low gap. Then the seven command bits, least significant bit first. All durations are whole multiples of a base delay unit, measured in clock cycles and set by a parameter.

Pulse `start_i` for one clock to request a transmission. The block latches `cmd_i` on that edge. It holds `busy_o` high until the last bit has been sent, then pulses `done_o` for one clock. Outside a transmission, `line_o` simply follows `vsel_i`. The eighth bit of a full switch command is not sent here: it sets the static `vsel_i` level.

Top module: `dsw_serializer`

## Requirements
- R1: In the first cycle after a synchronous reset, `busy_o` and `done_o` are 0 and `line_o` equals `vsel_i`.
- R2: While idle, `line_o` follows `vsel_i` in the same cycle.
- R3: A start accepted at a clock edge drives `line_o` to 1 from the next cycle, for START_UNITS×UNIT_CYC cycles (32 units by default).
- R4: After the start pulse, `line_o` is 0 for GAP_UNITS×UNIT_CYC cycles (8 units by default).
- R5: After the gap, command bits 0 through 6 appear on `line_o` in that order (bit 0 first). Each bit is held for BIT_UNITS×UNIT_CYC cycles (8 units by default).
- R6: `busy_o` is 1 in every cycle of the start pulse, the gap and the bit stream, and 0 otherwise.
- R7: In the first cycle after the last bit, `done_o` is 1 for exactly one cycle, `busy_o` is 0 and `line_o` equals `vsel_i` again.
- R8: A start strobe that arrives while `busy_o` is 1 is ignored. This includes the final bit cycle. The transmission in progress continues unchanged and no new one follows.
- R9: `cmd_i` is captured when a start is accepted. Later changes to it do not alter the bits being sent.
- R10: Changes to `vsel_i` during a transmission do not affect `line_o` until the block is idle again.
- R11: A start accepted in the cycle where `done_o` is 1 begins a new transmission at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a command |
| cmd_i | input | CMD_W | Command bits, captured on an accepted start |
| vsel_i | input | 1 | Static voltage-select level shown while idle |
| line_o | output | 1 | Shared switch/voltage-select line |
| busy_o | output | 1 | High while a transmission is in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
The assertions check four things on every cycle:
- the line follows the voltage select whenever the block is idle;
- the line is high during the start phase and low during the gap phase;
- the captured command stays frozen for the whole transmission;
- `done_o` appears only right after a busy cycle and lasts one cycle.

Some behaviour only the bench scenarios can show, because it depends on the exact cycle counts of each phase. This covers the length of each phase, the order of the bits, and that starts arriving mid-transmission are ignored. It also covers back-to-back starts, and command or voltage-select changes during a transmission. The bench's reference model predicts these as a stream of line values, one per cycle.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_GAP   = 2'd2,
        PH_BITS  = 2'd3
    } dsw_phase_e;

    // Number of delay units each phase lasts; PH_BITS is per bit.
    function automatic int unsigned phase_units(dsw_phase_e ph,
                                                int unsigned s_units,
                                                int unsigned g_units,
                                                int unsigned b_units);
        case (ph)
            PH_START: return s_units;
            PH_GAP:   return g_units;
            PH_BITS:  return b_units;
            default:  return 1;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dsw_unit_tick.sv
module dsw_unit_tick #(
    parameter int unsigned UNIT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (UNIT_CYC <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_count
            localparam int unsigned PW = $clog2(UNIT_CYC);
            localparam logic [PW-1:0] LAST = PW'(UNIT_CYC - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || !run_i) begin
                    pre_q <= '0;
                end else if (pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick_o = run_i && (pre_q == LAST);

            // R3
            pre_reset_chk: assert property (@(posedge clk) disable iff (rst)
                !run_i |=> (pre_q == '0));
        end
    endgenerate
endmodule

// File: rtl/dsw_seq.sv
module dsw_seq
    import dsw_pkg::*;
#(
    parameter int unsigned CMD_W       = 7,
    parameter int unsigned START_UNITS = 32,
    parameter int unsigned GAP_UNITS   = 8,
    parameter int unsigned BIT_UNITS   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             tick_i,
    output dsw_phase_e       phase_o,
    output logic             bit_o,
    output logic             done_o
);
    localparam int unsigned MAXU = max3(START_UNITS, GAP_UNITS, BIT_UNITS);
    localparam int unsigned UW   = (MAXU > 1) ? $clog2(MAXU) : 1;
    localparam int unsigned IW   = (CMD_W > 1) ? $clog2(CMD_W) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(CMD_W - 1);

    dsw_phase_e       phase_q;
    logic [UW-1:0]    ucnt_q;
    logic [IW-1:0]    idx_q;
    logic [CMD_W-1:0] cmd_q;
    logic             done_q;
    logic [UW-1:0]    lim_m1;

    always_comb begin
        lim_m1 = UW'(phase_units(phase_q, START_UNITS, GAP_UNITS, BIT_UNITS) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ucnt_q  <= '0;
            idx_q   <= '0;
            cmd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (start_i) begin
                    phase_q <= PH_START;
                    cmd_q   <= cmd_i;
                    ucnt_q  <= '0;
                    idx_q   <= '0;
                end
            end else if (tick_i) begin
                if (ucnt_q == lim_m1) begin
                    ucnt_q <= '0;
                    unique case (phase_q)
                        PH_START: phase_q <= PH_GAP;
                        PH_GAP:   phase_q <= PH_BITS;
                        default: begin
                            if (idx_q == LAST_BIT) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    endcase
                end else begin
                    ucnt_q <= ucnt_q + 1'b1;
                end
            end
        end
    end

    assign phase_o = phase_q;
    assign bit_o   = cmd_q[idx_q];
    assign done_o  = done_q;

    // R9
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> ((phase_q == PH_IDLE) || $stable(cmd_q)));

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_BIT);
endmodule

// File: rtl/dsw_line_drv.sv
module dsw_line_drv
    import dsw_pkg::*;
(
    input  dsw_phase_e phase_i,
    input  logic       bit_i,
    input  logic       vsel_i,
    output logic       line_o,
    output logic       busy_o
);
    always_comb begin
        unique case (phase_i)
            PH_START: line_o = 1'b1;
            PH_GAP:   line_o = 1'b0;
            PH_BITS:  line_o = bit_i;
            default:  line_o = vsel_i;
        endcase
    end

    assign busy_o = (phase_i != PH_IDLE);
endmodule

// File: rtl/dsw_serializer.sv
module dsw_serializer
    import dsw_pkg::*;
#(
    parameter int unsigned CMD_W       = 7,
    parameter int unsigned UNIT_CYC    = 4,
    parameter int unsigned START_UNITS = 32,
    parameter int unsigned GAP_UNITS   = 8,
    parameter int unsigned BIT_UNITS   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             vsel_i,
    output logic             line_o,
    output logic             busy_o,
    output logic             done_o
);
    dsw_phase_e phase;
    logic       tick;
    logic       cur_bit;

    dsw_unit_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (phase != PH_IDLE),
        .tick_o (tick)
    );

    dsw_seq #(
        .CMD_W       (CMD_W),
        .START_UNITS (START_UNITS),
        .GAP_UNITS   (GAP_UNITS),
        .BIT_UNITS   (BIT_UNITS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmd_i   (cmd_i),
        .tick_i  (tick),
        .phase_o (phase),
        .bit_o   (cur_bit),
        .done_o  (done_o)
    );

    dsw_line_drv u_drv (
        .phase_i (phase),
        .bit_i   (cur_bit),
        .vsel_i  (vsel_i),
        .line_o  (line_o),
        .busy_o  (busy_o)
    );

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (line_o == vsel_i));

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START) |-> line_o);

    // R4
    gap_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP) |-> !line_o);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/tb_dsw_serializer.sv
`timescale 1ns/1ps
module tb_dsw_serializer;
    localparam int unsigned CMD_W = 7;
    localparam int unsigned U     = 3;
    localparam int unsigned SU    = 32;
    localparam int unsigned GU    = 8;
    localparam int unsigned BU    = 8;
    localparam int unsigned TX_CYC = (SU + GU + CMD_W * BU) * U;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [CMD_W-1:0] cmd_i;
    logic             vsel_i;
    logic             line_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dsw_serializer #(
        .CMD_W(CMD_W), .UNIT_CYC(U), .START_UNITS(SU), .GAP_UNITS(GU), .BIT_UNITS(BU)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i),
        .vsel_i(vsel_i), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Reference model: queue of line values still to come in this transmission
    bit    q_val[$];
    string q_tag[$];
    bit    m_busy = 0;
    bit    m_val  = 0;
    bit    m_done = 0;
    bit    m_rst  = 1;
    string m_tag  = "R1";
    bit    m_valid = 0;

    always @(posedge clk) begin
        m_valid = 1;
        m_done  = 0;
        if (rst) begin
            q_val.delete();
            q_tag.delete();
            m_busy = 0;
            m_rst  = 1;
            m_tag  = "R1";
        end else begin
            m_rst = 0;
            if (m_busy) begin
                if (q_val.size() > 0) begin
                    m_val = q_val.pop_front();
                    m_tag = q_tag.pop_front();
                end else begin
                    m_busy = 0;
                    m_done = 1;
                    m_tag  = "R7";
                end
            end else if (start_i) begin
                for (int i = 0; i < SU * U; i++) begin q_val.push_back(1'b1); q_tag.push_back("R3"); end
                for (int i = 0; i < GU * U; i++) begin q_val.push_back(1'b0); q_tag.push_back("R4"); end
                for (int b = 0; b < CMD_W; b++)
                    for (int k = 0; k < BU * U; k++) begin
                        q_val.push_back(cmd_i[b]); q_tag.push_back("R5");
                    end
                m_val  = q_val.pop_front();
                m_tag  = q_tag.pop_front();
                m_busy = 1;
            end else begin
                m_tag = "R2";
            end
        end
    end

    task automatic check1(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every cycle, 8 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #8;
            if (m_valid && !finished) begin
                check1(m_tag, line_o, m_busy ? m_val : vsel_i, "line_o");
                check1(m_rst ? "R1" : "R6", busy_o, m_busy, "busy_o");
                check1(m_rst ? "R1" : "R7", done_o, m_done, "done_o");
            end
        end
    end

    task automatic send(logic [CMD_W-1:0] c);
        @(negedge clk);
        start_i = 1'b1;
        cmd_i   = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; cmd_i = '0; vsel_i = 1'b0;
        idle_cycles(3);
        vsel_i = 1'b1;               // R1: line tracks vsel during reset
        idle_cycles(2);
        rst = 1'b0;
        // R2: idle line follows vsel changes
        idle_cycles(2); vsel_i = 1'b0; idle_cycles(2); vsel_i = 1'b1; idle_cycles(2);
        // R3 R4 R5 R6 R7: patterns with both static levels
        vsel_i = 1'b0; send(7'h55); idle_cycles(TX_CYC + 4);
        vsel_i = 1'b1; send(7'h2A); idle_cycles(TX_CYC + 4);
        send(7'h01); idle_cycles(TX_CYC + 4);
        vsel_i = 1'b0; send(7'h7F); idle_cycles(TX_CYC + 4);
        send(7'h00); idle_cycles(TX_CYC + 4);
        // R8 R9 R10: disturb inputs mid-transmission
        send(7'h4D);
        idle_cycles(40);
        cmd_i = 7'h12; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        vsel_i = 1'b1; idle_cycles(150);
        cmd_i = 7'h3C; vsel_i = 1'b0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        // R8: strobe held over the final bit cycle must not restart
        idle_cycles(TX_CYC - 193);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        idle_cycles(12);
        // R11: start presented exactly in the done cycle
        send(7'h33);
        wait (done_o === 1'b1);
        @(negedge clk);
        start_i = 1'b1; cmd_i = 7'h6B; @(negedge clk); start_i = 1'b0;
        idle_cycles(TX_CYC + 6);
        finish_run();
    end
endmodule